// File: doc/BRIEF.md
# Master-Clock Ratio Detector and Lock Monitor

This block watches a master clock and the word clock that marks each audio sample. It finds out whether the master clock runs at 256, 384 or 512 times the sample rate and reports the result as a ratio code. From that code it produces a single-cycle tick at the 256x rate, so the logic downstream always sees 256 ticks per sample period, whichever master clock is fitted.

After the active-low reset is released, the block runs an initialization interval of a fixed number of master-clock cycles. It treats power-on the same way, provided the reset input is held low while the master clock starts. Once running, it times every word-clock period against the locked ratio. The allowed slack is six bit-clock periods, where the bit-clock period is measured in master-clock cycles. A period outside that window drops lock, and the force-zero output rises so that converter outputs are held at mid-scale. Force-zero is released only after lock has held for 32 sample periods in a row.

The word and bit clocks are taken to be synchronous to the master clock. Each is registered twice before edges are detected, and reset is sampled synchronously.

Top module: `mclk_ratio_monitor`

## Requirements
- R1: At the second master-clock edge after a word-clock rise that closes a period of exactly 256, 384 or 512 master-clock cycles, `ratio_code` takes the value 1, 2 or 3 respectively. Code 0 means no ratio has been found since reset.
- R2: A period whose length is not one of the three ratios leaves `ratio_code` unchanged and sets `ratio_err`. The next period of valid length clears `ratio_err`.
- R3: `tick256` fires 256 times in every steady word-clock period: on every cycle at code 1, on two cycles out of three at code 2, and on every second cycle at code 3. It is never high while the code is 0.
- R4: `init_busy` is 1 while `rst_n` is sampled low. After release it stays 1 for exactly 1024 master-clock edges at which `rst_n` is sampled high, then falls. Any low sample restarts the full count.
- R5: While `init_busy` is 1, `ratio_code` is 0, `tick256` and `sync_ok` are 0, and `force_zero` is 1.
- R6: Once a ratio is locked, `sync_ok` falls when a period deviates from the expected length by more than six measured bit-clock periods. A late word-clock edge is caught as soon as the running count passes the window, without waiting for that edge.
- R7: A deviation of six bit-clock periods or less, including exactly six, keeps `sync_ok` at 1, even when the length is not a valid ratio.
- R8: `force_zero` is 1 whenever `sync_ok` is 0.
- R9: `force_zero` falls at the edge that accepts the 32nd consecutive in-window period. Any out-of-window period restarts that count.
- R10: A period of a different valid ratio is adopted as the new `ratio_code`, but it counts as a loss of lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all logic is clocked on its rising edge |
| rst_n | input | 1 | Active-low reset, sampled synchronously |
| wclk | input | 1 | Word clock at the sample rate; its rising edge starts a period |
| bclk | input | 1 | Bit clock; its period sets the lock window |
| ratio_code | output | 2 | 0 none, 1 for 256x, 2 for 384x, 3 for 512x |
| ratio_err | output | 1 | Last period length was not a valid ratio |
| tick256 | output | 1 | Enable strobe at 256 times the sample rate |
| init_busy | output | 1 | Initialization interval in progress |
| sync_ok | output | 1 | Word clock is within the lock window |
| force_zero | output | 1 | Hold converter outputs at mid-scale |

## Verification
A word-clock rise driven just after a master-clock edge is registered at the next edge and acted on at the edge after that. The bench therefore samples ratio, error, lock and force-zero at the falling edge two cycles into the following frame, which is after both registers and before the next frame can disturb them. Init length is counted as falling-edge samples of `init_busy` starting at the first edge that sees `rst_n` high. Tick counts are taken over a whole steady frame, so the one-cycle pipeline offset does not change the total.

// File: rtl/mrm_pkg.sv
package mrm_pkg;

    localparam int BASE_RATIO = 256;
    localparam int MID_RATIO  = BASE_RATIO + BASE_RATIO / 2;
    localparam int MAX_RATIO  = 2 * BASE_RATIO;
    // room for a period of several times the largest ratio before saturation
    localparam int CNT_W      = $clog2(MAX_RATIO) + 3;

    typedef enum logic [1:0] {
        RATIO_NONE = 2'd0,
        RATIO_256  = 2'd1,
        RATIO_384  = 2'd2,
        RATIO_512  = 2'd3
    } ratio_e;

    typedef struct packed {
        ratio_e code;
        logic   err;
        logic   sync;
        logic   released;
    } lock_st_t;

    function automatic logic [CNT_W-1:0] ratio_len(ratio_e r);
        case (r)
            RATIO_256: ratio_len = CNT_W'(BASE_RATIO);
            RATIO_384: ratio_len = CNT_W'(MID_RATIO);
            RATIO_512: ratio_len = CNT_W'(MAX_RATIO);
            default:   ratio_len = '0;
        endcase
    endfunction

    function automatic ratio_e classify(logic [CNT_W-1:0] n);
        if (n == CNT_W'(BASE_RATIO))     classify = RATIO_256;
        else if (n == CNT_W'(MID_RATIO)) classify = RATIO_384;
        else if (n == CNT_W'(MAX_RATIO)) classify = RATIO_512;
        else                             classify = RATIO_NONE;
    endfunction

endpackage

// File: rtl/mrm_init_seq.sv
module mrm_init_seq #(
    parameter int INIT_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    output logic busy
);
    localparam int CW = $clog2(INIT_CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            busy <= 1'b1;
        end else if (busy) begin
            if (cnt == CW'(INIT_CYCLES)) busy <= 1'b0;
            else                         cnt  <= cnt + CW'(1);
        end
    end

    // R4
    init_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(cnt) == CW'(INIT_CYCLES)));

endmodule

// File: rtl/mrm_edge_meter.sv
module mrm_edge_meter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         sig,
    output logic         rise,
    output logic         seen,
    output logic [W-1:0] run
);
    logic s_q, s_qq;

    assign rise = s_q & ~s_qq;

    always_ff @(posedge clk) begin
        if (clr) begin
            s_q  <= 1'b0;
            s_qq <= 1'b0;
            seen <= 1'b0;
            run  <= '0;
        end else begin
            s_q  <= sig;
            s_qq <= s_q;
            if (rise) begin
                seen <= 1'b1;
                run  <= W'(1);
            end else if (run != '1) begin
                run  <= run + W'(1);
            end
        end
    end

endmodule

// File: rtl/mrm_lock_fsm.sv
module mrm_lock_fsm
    import mrm_pkg::*;
#(
    parameter int BP_W   = 6,
    parameter int SETTLE = 32
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             w_rise,
    input  logic             w_seen,
    input  logic [CNT_W-1:0] w_run,
    input  logic             b_rise,
    input  logic             b_seen,
    input  logic [BP_W-1:0]  b_run,
    output lock_st_t         st
);
    localparam int TOL_W = BP_W + 3;
    localparam int CMP_W = ((CNT_W > TOL_W) ? CNT_W : TOL_W) + 2;
    localparam int SET_W = $clog2(SETTLE + 1);

    logic [BP_W-1:0]  bper;
    ratio_e           code;
    logic             err, sync, released;
    logic [SET_W-1:0] settle;

    logic [CMP_W-1:0] tol, exp_c, run_c;
    ratio_e           cls;
    logic             locked, in_tol, period_ev, good, overdue;

    always_comb begin
        tol       = CMP_W'({bper, 2'b00}) + CMP_W'({bper, 1'b0});
        exp_c     = CMP_W'(ratio_len(code));
        run_c     = CMP_W'(w_run);
        cls       = classify(w_run);
        locked    = (code != RATIO_NONE);
        in_tol    = (run_c + tol >= exp_c) && (run_c <= exp_c + tol);
        period_ev = w_rise && w_seen;
        if (locked)
            good = period_ev && in_tol && ((cls == RATIO_NONE) || (cls == code));
        else
            good = period_ev && (cls != RATIO_NONE);
        overdue   = locked && !w_rise && (run_c > exp_c + tol);
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            bper     <= '0;
            code     <= RATIO_NONE;
            err      <= 1'b0;
            sync     <= 1'b0;
            released <= 1'b0;
            settle   <= '0;
        end else begin
            if (b_rise && b_seen) bper <= b_run;
            if (period_ev) begin
                if (cls != RATIO_NONE) begin
                    code <= cls;
                    err  <= 1'b0;
                end else begin
                    err  <= 1'b1;
                end
            end
            if (good) begin
                sync <= 1'b1;
                if (settle != SET_W'(SETTLE)) settle <= settle + SET_W'(1);
                if (settle >= SET_W'(SETTLE - 1)) released <= 1'b1;
            end else if (period_ev || overdue) begin
                sync     <= 1'b0;
                settle   <= '0;
                released <= 1'b0;
            end
        end
    end

    assign st = '{code: code, err: err, sync: sync, released: released};

    // R2
    hold_on_bad_len_chk: assert property (@(posedge clk) disable iff (clr)
        (period_ev && cls == RATIO_NONE) |=> $stable(code));

    // R6
    overdue_loss_chk: assert property (@(posedge clk) disable iff (clr)
        overdue |=> !sync);

    // R9
    release_needs_sync_chk: assert property (@(posedge clk) disable iff (clr)
        $rose(released) |-> sync);

    // R10
    ratio_switch_chk: assert property (@(posedge clk) disable iff (clr)
        (period_ev && locked && cls != RATIO_NONE && cls != code) |=> (!sync && code == $past(cls)));

endmodule

// File: rtl/mrm_tick_gen.sv
module mrm_tick_gen
    import mrm_pkg::*;
(
    input  logic   clk,
    input  logic   clr,
    input  logic   rise,
    input  ratio_e code,
    output logic   tick
);
    logic [1:0] phase, eff, nxt;

    always_comb begin
        eff = rise ? 2'd0 : phase;
        case (code)
            RATIO_256: begin tick = 1'b1;           nxt = 2'd0; end
            RATIO_384: begin tick = (eff != 2'd2);  nxt = (eff == 2'd2) ? 2'd0 : eff + 2'd1; end
            RATIO_512: begin tick = (eff == 2'd0);  nxt = {1'b0, ~eff[0]}; end
            default:   begin tick = 1'b0;           nxt = 2'd0; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (clr) phase <= 2'd0;
        else     phase <= nxt;
    end

    // R3
    tick_needs_ratio_chk: assert property (@(posedge clk) disable iff (clr)
        tick |-> (code != RATIO_NONE));

    // R3
    tick_half_rate_chk: assert property (@(posedge clk) disable iff (clr)
        (code == RATIO_512 && tick && !rise) |=> (!tick || rise));

endmodule

// File: rtl/mclk_ratio_monitor.sv
module mclk_ratio_monitor
    import mrm_pkg::*;
#(
    parameter int INIT_CYCLES   = 1024,
    parameter int SETTLE_FRAMES = 32,
    parameter int BP_W          = 6
) (
    input  logic       mclk,
    input  logic       rst_n,
    input  logic       wclk,
    input  logic       bclk,
    output logic [1:0] ratio_code,
    output logic       ratio_err,
    output logic       tick256,
    output logic       init_busy,
    output logic       sync_ok,
    output logic       force_zero
);
    logic             busy, clr;
    logic             w_rise, w_seen, b_rise, b_seen;
    logic [CNT_W-1:0] w_run;
    logic [BP_W-1:0]  b_run;
    lock_st_t         st;

    assign clr = busy | ~rst_n;

    mrm_init_seq #(.INIT_CYCLES(INIT_CYCLES)) u_init (
        .clk(mclk), .rst_n(rst_n), .busy(busy)
    );

    mrm_edge_meter #(.W(CNT_W)) u_wmeter (
        .clk(mclk), .clr(clr), .sig(wclk),
        .rise(w_rise), .seen(w_seen), .run(w_run)
    );

    mrm_edge_meter #(.W(BP_W)) u_bmeter (
        .clk(mclk), .clr(clr), .sig(bclk),
        .rise(b_rise), .seen(b_seen), .run(b_run)
    );

    mrm_lock_fsm #(.BP_W(BP_W), .SETTLE(SETTLE_FRAMES)) u_lock (
        .clk(mclk), .clr(clr),
        .w_rise(w_rise), .w_seen(w_seen), .w_run(w_run),
        .b_rise(b_rise), .b_seen(b_seen), .b_run(b_run),
        .st(st)
    );

    mrm_tick_gen u_tick (
        .clk(mclk), .clr(clr), .rise(w_rise), .code(st.code), .tick(tick256)
    );

    assign ratio_code = st.code;
    assign ratio_err  = st.err;
    assign sync_ok    = st.sync;
    assign init_busy  = busy;
    assign force_zero = busy | ~st.released;

    // R5
    init_quiet_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        init_busy |-> (ratio_code == 2'd0 && !tick256 && !sync_ok));

    // R8
    unlocked_zero_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        !sync_ok |-> force_zero);

endmodule

// File: tb/mclk_ratio_monitor_bench.sv
`timescale 1ns/1ps
module mclk_ratio_monitor_bench;

    localparam int INIT = 1024;

    logic       mclk  = 1'b0;
    logic       rst_n = 1'b0;
    logic       wclk  = 1'b0;
    logic       bclk  = 1'b0;
    logic [1:0] ratio_code;
    logic       ratio_err, tick256, init_busy, sync_ok, force_zero;

    int  total = 0;
    int  fails = 0;
    int  gcnt  = 0;
    logic rst_req = 1'b0;

    always #5 mclk = ~mclk;

    mclk_ratio_monitor u_mclk_ratio_monitor (
        .mclk(mclk), .rst_n(rst_n), .wclk(wclk), .bclk(bclk),
        .ratio_code(ratio_code), .ratio_err(ratio_err), .tick256(tick256),
        .init_busy(init_busy), .sync_ok(sync_ok), .force_zero(force_zero)
    );

    typedef struct packed {
        int len; int bp; int reps;
        int code; int sync; int err; int fz; int stb;
    } vec_t;

    // Each row: reps frames of len cycles, bit period bp; the expected columns
    // are the state once the last of those frames has been closed.
    localparam int NV = 21;
    localparam vec_t TBL [NV] = '{
        '{256, 4,  1, 1, 1, 0, 1,   0},  // R1 first lock; R3 no tick while unlocked
        '{256, 4, 30, 1, 1, 0, 1, 256},  // R3 one tick per cycle
        '{256, 4,  1, 1, 1, 0, 0,  -1},  // R9 32nd good period releases
        '{270, 4,  1, 1, 1, 1, 0,  -1},  // R2 R7 long but in window
        '{250, 4,  1, 1, 1, 1, 0,  -1},  // R7 short but in window
        '{256, 4,  1, 1, 1, 0, 0,  -1},  // R2 error clears
        '{281, 4,  1, 1, 0, 1, 1,  -1},  // R6 R8 late edge
        '{256, 4,  1, 1, 1, 0, 1,  -1},  // R9 relocked, still held
        '{256, 4, 31, 1, 1, 0, 0,  -1},  // R9
        '{230, 4,  1, 1, 0, 1, 1,  -1},  // R6 early edge
        '{256, 4, 20, 1, 1, 0, 1,  -1},  // R9 partial settle
        '{200, 4,  1, 1, 0, 1, 1,  -1},  // R9 restart on loss
        '{256, 4, 32, 1, 1, 0, 0,  -1},  // R9
        '{384, 6,  1, 2, 0, 0, 1,  -1},  // R10 switch to 384
        '{384, 6, 32, 2, 1, 0, 0, 256},  // R1 R3 two of three
        '{414, 6,  1, 2, 1, 1, 0,  -1},  // R7 window of 36
        '{512, 8,  1, 3, 0, 0, 1,  -1},  // R10 switch to 512
        '{512, 8, 32, 3, 1, 0, 0, 256},  // R1 R3 every other cycle
        '{560, 8,  1, 3, 1, 1, 0,  -1},  // R7 exactly six bit periods
        '{561, 8,  1, 3, 0, 1, 1,  -1},  // R6 one cycle past the window
        '{512, 8,  1, 0, 0, 0, 0,  -1}   // closes the previous row only
    };

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // one master-clock cycle: drive after the rising edge, return at the falling edge
    task automatic drive_cycle(input logic w, input int bp);
        @(posedge mclk);
        #1;
        rst_n = rst_req;
        wclk  = w;
        bclk  = ((gcnt % bp) < (bp / 2));
        gcnt++;
        @(negedge mclk);
    endtask

    task automatic check_row(input vec_t v);
        chk("R1", "ratio_code", int'(ratio_code), v.code);
        chk("R2", "ratio_err", int'(ratio_err), v.err);
        chk("R6", "sync_ok", int'(sync_ok), v.sync);
        chk("R9", "force_zero", int'(force_zero), v.fz);
    endtask

    // R4: counts busy samples from the first edge that sees rst_n high
    task automatic count_init(output int n);
        n = 0;
        rst_req = 1'b1;
        drive_cycle(1'b0, 4);
        for (int i = 0; i < 3 * INIT; i++) begin
            drive_cycle(1'b0, 4);
            if (init_busy) n++;
            else break;
        end
    endtask

    task automatic drive_frame(input int k, input int r);
        int ticks;
        ticks = 0;
        for (int i = 0; i < TBL[k].len; i++) begin
            drive_cycle(i < TBL[k].len / 2, TBL[k].bp);
            if (tick256) ticks++;
            if (i == 2 && r == 0) begin
                if (k > 0) check_row(TBL[k-1]);
                else begin
                    // R5 R8: nothing locked yet after init
                    chk("R1", "ratio_code before first period", int'(ratio_code), 0);
                    chk("R8", "force_zero before lock", int'(force_zero), 1);
                end
            end
        end
        if (r == TBL[k].reps - 1 && TBL[k].stb >= 0 && k < NV - 1)
            chk("R3", "ticks per frame", ticks, TBL[k].stb);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        #1900000;
        total++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        int n;
        rst_req = 1'b0;
        for (int i = 0; i < 4; i++) drive_cycle(1'b0, 4);
        // R4 R5 reset state
        chk("R4", "init_busy in reset", int'(init_busy), 1);
        chk("R5", "force_zero in reset", int'(force_zero), 1);
        chk("R5", "ratio_code in reset", int'(ratio_code), 0);
        chk("R5", "sync_ok in reset", int'(sync_ok), 0);
        chk("R5", "tick256 in reset", int'(tick256), 0);
        chk("R2", "ratio_err in reset", int'(ratio_err), 0);

        count_init(n);
        chk("R4", "init length", n, INIT);
        chk("R8", "force_zero after init", int'(force_zero), 1);

        for (int i = 0; i < 20; i++) drive_cycle(1'b0, 4);

        for (int k = 0; k < NV; k++)
            for (int r = 0; r < TBL[k].reps; r++)
                drive_frame(k, r);

        // R4 R5: reset while running clears the lock
        rst_req = 1'b0;
        drive_cycle(1'b0, 8);
        drive_cycle(1'b0, 8);
        chk("R4", "init_busy after reset", int'(init_busy), 1);
        chk("R5", "ratio_code after reset", int'(ratio_code), 0);
        chk("R5", "sync_ok after reset", int'(sync_ok), 0);
        chk("R5", "force_zero after reset", int'(force_zero), 1);

        // R4: a low sample in mid-init restarts the whole count
        rst_req = 1'b1;
        for (int i = 0; i < 500; i++) drive_cycle(1'b0, 4);
        rst_req = 1'b0;
        drive_cycle(1'b0, 4);
        count_init(n);
        chk("R4", "init length after restart", n, INIT);

        finish_run();
    end

endmodule